// File: doc/BRIEF.md
# Register Rename Map with Trap and Mispredict Recovery

This block translates the architectural register numbers of one instruction per cycle into physical register numbers. Each source is looked up in a speculative map that always holds the newest mapping. A nonzero destination takes a fresh physical register from a free pool, and the speculative map then points at it. A second, committed map changes only when an instruction retires. The physical register that the retiring destination used to hold goes back to the pool.

Two recovery paths restore the speculative map. A trap copies the committed map over the speculative map in one cycle. A mispredict also starts from the committed map, and then enters a rebuild phase. In that phase the surrounding core replays the destination mappings of the older in-flight instructions that survive, oldest first, until it signals that the replay is done. In both cases the pool is recomputed as every physical register that the committed map does not reference, so registers held by squashed instructions come back before renaming resumes. Registers replayed during a rebuild are then taken out of the pool again.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, each architectural register a maps to physical register a, both maps agree, the free pool holds physical registers 32 to 63, and `ren_ready` is 1.
- R2: `ren_psrc1` and `ren_psrc2` show the speculative mapping of their sources in the same cycle. Architectural register 0 always reads as physical 0. A source equal to the instruction's own destination reads the mapping from before that instruction.
- R3: An accepted request (`ren_valid` and `ren_ready`) with a nonzero destination gets the lowest-numbered free physical register on `ren_pdst` in the same cycle, and that register leaves the pool. From the next cycle, the destination reads as that register. A destination of 0 allocates nothing and shows `ren_pdst` = 0.
- R4: `ren_ready` is 0 whenever the pool is empty, and a request that is not accepted changes no state.
- R5: A retirement (`cmt_valid`, nonzero `cmt_dst`) writes `cmt_pdst` into the committed map and returns the physical register previously committed for that destination to the pool.
- R6: On `trap`, the speculative map equals the committed map (including a retirement in the same cycle) from the next cycle on. The pool then holds every physical register that the committed map does not reference. A trap also ends a rebuild.
- R7: On `mispredict`, the maps and the pool are reset as for a trap, and a rebuild starts. Each `rp_valid` cycle writes `rp_pdst` into the speculative entry `rp_dst` and removes it from the pool, so a later replay of the same register wins. `ren_ready` stays 0 until the cycle after `rp_done`.
- R8: In a cycle where `trap` or `mispredict` is high, `ren_ready` is 0 and a rename request in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Request can be accepted this cycle |
| ren_src1 | input | 5 | First architectural source |
| ren_src2 | input | 5 | Second architectural source |
| ren_dst | input | 5 | Architectural destination, 0 for none |
| ren_psrc1 | output | 6 | Physical register for first source |
| ren_psrc2 | output | 6 | Physical register for second source |
| ren_pdst | output | 6 | Physical register allocated to destination |
| cmt_valid | input | 1 | An instruction retires |
| cmt_dst | input | 5 | Retiring architectural destination |
| cmt_pdst | input | 6 | Retiring physical destination |
| trap | input | 1 | Restore speculative map from committed map |
| mispredict | input | 1 | Restore and begin rebuild |
| rp_valid | input | 1 | Replayed surviving mapping present |
| rp_dst | input | 5 | Replayed architectural destination |
| rp_pdst | input | 6 | Replayed physical destination |
| rp_done | input | 1 | Replay finished |

## Verification
A corrupted speculative entry shows on the source outputs in the first cycle a later instruction names that register. A leaking or doubly granted pool entry shows on `ren_pdst` as soon as allocation reaches that index in lowest-first order. The bench therefore follows every recovery with a rename whose expected source and destination numbers follow only from the committed map and the replay list. It also drains the pool completely, which exposes a stale pool bit within the number of allocations left before the pool is empty.

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ren_valid,
  output logic                        ren_ready,
  input  logic [$clog2(NUM_ARCH)-1:0] ren_src1,
  input  logic [$clog2(NUM_ARCH)-1:0] ren_src2,
  input  logic [$clog2(NUM_ARCH)-1:0] ren_dst,
  output logic [$clog2(NUM_PHYS)-1:0] ren_psrc1,
  output logic [$clog2(NUM_PHYS)-1:0] ren_psrc2,
  output logic [$clog2(NUM_PHYS)-1:0] ren_pdst,
  input  logic                        cmt_valid,
  input  logic [$clog2(NUM_ARCH)-1:0] cmt_dst,
  input  logic [$clog2(NUM_PHYS)-1:0] cmt_pdst,
  input  logic                        trap,
  input  logic                        mispredict,
  input  logic                        rp_valid,
  input  logic [$clog2(NUM_ARCH)-1:0] rp_dst,
  input  logic [$clog2(NUM_PHYS)-1:0] rp_pdst,
  input  logic                        rp_done
);
  localparam int AW = $clog2(NUM_ARCH);
  localparam int PW = $clog2(NUM_PHYS);

  logic [NUM_ARCH-1:0][PW-1:0] spec_map, cmt_map, cmt_map_nxt;
  logic [NUM_PHYS-1:0]         free_pool, live, alloc_oh, retire_oh, replay_oh;
  logic [PW-1:0]               pick;
  logic                        rebuilding, fire, recover;

  assign recover   = trap | mispredict;
  assign ren_ready = !rebuilding && !recover && (|free_pool);
  assign fire      = ren_valid && ren_ready;
  assign ren_psrc1 = spec_map[ren_src1];
  assign ren_psrc2 = spec_map[ren_src2];
  assign ren_pdst  = (ren_dst != '0 && (|free_pool)) ? pick : '0;

  always_comb begin
    pick = '0;
    for (int p = NUM_PHYS - 1; p >= 0; p--)
      if (free_pool[p]) pick = PW'(p);
  end

  always_comb begin
    cmt_map_nxt = cmt_map;
    retire_oh   = '0;
    if (cmt_valid && cmt_dst != '0) begin
      cmt_map_nxt[cmt_dst]       = cmt_pdst;
      retire_oh[cmt_map[cmt_dst]] = 1'b1;
    end
    live = '0;
    for (int a = 0; a < NUM_ARCH; a++) live[cmt_map_nxt[a]] = 1'b1;
    alloc_oh = '0;
    if (fire && ren_dst != '0) alloc_oh[pick] = 1'b1;
    replay_oh = '0;
    if (rebuilding && rp_valid) replay_oh[rp_pdst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        spec_map[a] <= PW'(a);
        cmt_map[a]  <= PW'(a);
      end
      for (int p = 0; p < NUM_PHYS; p++) free_pool[p] <= (p >= NUM_ARCH);
      rebuilding <= 1'b0;
    end else begin
      cmt_map <= cmt_map_nxt;
      if (recover) begin
        spec_map   <= cmt_map_nxt;
        free_pool  <= ~live;
        rebuilding <= mispredict && !trap;
      end else begin
        if (fire && ren_dst != '0) spec_map[ren_dst] <= pick;
        if (rebuilding && rp_valid && rp_dst != '0) spec_map[rp_dst] <= rp_pdst;
        free_pool <= (free_pool & ~alloc_oh & ~replay_oh) | retire_oh;
        if (rebuilding && rp_done) rebuilding <= 1'b0;
      end
    end
  end

  // R2
  zero_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_map[0] == '0 && cmt_map[0] == '0);

  // R3
  grant_leaves_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ren_dst != '0 && !recover) |=> !free_pool[$past(ren_pdst)]);

  // R5
  retire_frees_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_dst != '0 && !rp_valid) |=> free_pool[$past(cmt_map[cmt_dst])]);

  // R6
  trap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (spec_map == cmt_map));

  // R7
  rebuild_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rebuilding) |-> $past(mispredict));
endmodule

// File: tb/rename_map_unit_test.sv
module rename_map_unit_test;
  logic clk = 0, rst_n = 0;
  logic ren_valid = 0, ren_ready;
  logic [4:0] ren_src1 = 0, ren_src2 = 0, ren_dst = 0;
  logic [5:0] ren_psrc1, ren_psrc2, ren_pdst;
  logic cmt_valid = 0; logic [4:0] cmt_dst = 0; logic [5:0] cmt_pdst = 0;
  logic trap = 0, mispredict = 0;
  logic rp_valid = 0, rp_done = 0; logic [4:0] rp_dst = 0; logic [5:0] rp_pdst = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rename_map_unit uut (.*);

  // {src1, src2, dst, exp_psrc1, exp_psrc2, exp_pdst}
  localparam logic [32:0] VEC [7] = '{
    {5'd1,  5'd2,  5'd3,  6'd1,  6'd2,  6'd32},
    {5'd3,  5'd0,  5'd3,  6'd32, 6'd0,  6'd33},
    {5'd3,  5'd4,  5'd0,  6'd33, 6'd4,  6'd0 },
    {5'd5,  5'd3,  5'd5,  6'd5,  6'd33, 6'd34},
    {5'd5,  5'd31, 5'd31, 6'd34, 6'd31, 6'd35},
    {5'd31, 5'd1,  5'd1,  6'd35, 6'd1,  6'd36},
    {5'd1,  5'd3,  5'd7,  6'd36, 6'd33, 6'd37}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ren_op(input logic [4:0] s1, s2, d,
                        output logic r, output logic [5:0] p1, p2, pd);
    @(negedge clk);
    ren_valid = 1; ren_src1 = s1; ren_src2 = s2; ren_dst = d;
    #1 r = ren_ready; p1 = ren_psrc1; p2 = ren_psrc2; pd = ren_pdst;
    @(posedge clk); #1 ren_valid = 0;
  endtask

  task automatic retire(input logic [4:0] d, input logic [5:0] p);
    @(negedge clk); cmt_valid = 1; cmt_dst = d; cmt_pdst = p;
    @(posedge clk); #1 cmt_valid = 0;
  endtask

  task automatic replay(input logic [4:0] d, input logic [5:0] p);
    @(negedge clk); rp_valid = 1; rp_dst = d; rp_pdst = p; ren_valid = 1; ren_dst = 15;
    #1 chk(!ren_ready, "R7 ready during rebuild", ren_ready, 0);
    @(posedge clk); #1 rp_valid = 0; ren_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    logic r; logic [5:0] p1, p2, pd;
    int bad;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(ren_ready == 1, "R1 ready after reset", ren_ready, 1);

    // R1 R2 R3: table walk from reset state
    for (int i = 0; i < 7; i++) begin
      ren_op(VEC[i][32:28], VEC[i][27:23], VEC[i][22:18], r, p1, p2, pd);
      chk(r && p1 == VEC[i][17:12] && p2 == VEC[i][11:6] && pd == VEC[i][5:0],
          "R2/R3 table vector", {r, p1, p2, pd}, {1'b1, VEC[i][17:0]});
    end

    // R5: retiring returns the previous committed register
    retire(3, 32);
    retire(3, 33);
    ren_op(2, 3, 2, r, p1, p2, pd);
    chk(pd == 3, "R5 old mapping returned", pd, 3);
    chk(p2 == 33, "R2 source reads newest", p2, 33);

    // R6: trap restores from committed map, squashed regs freed
    @(negedge clk); trap = 1;
    @(posedge clk); #1 trap = 0;
    ren_op(3, 5, 9, r, p1, p2, pd);
    chk(p1 == 33 && p2 == 5, "R6 sources after trap", {p1, p2}, {6'd33, 6'd5});
    chk(pd == 3, "R6 pool recomputed", pd, 3);

    // R7: mispredict with replay
    ren_op(0, 0, 10, r, p1, p2, pd);
    chk(pd == 32, "R3 lowest free", pd, 32);
    ren_op(0, 0, 10, r, p1, p2, pd);
    chk(pd == 34, "R3 lowest free", pd, 34);
    ren_op(0, 0, 12, r, p1, p2, pd);
    chk(pd == 35, "R3 lowest free", pd, 35);
    @(negedge clk); mispredict = 1; ren_valid = 1; ren_dst = 14;
    #1 chk(!ren_ready, "R8 ready in recovery cycle", ren_ready, 0);
    @(posedge clk); #1 mispredict = 0; ren_valid = 0;
    replay(9, 3);
    replay(10, 32);
    replay(10, 34);
    @(negedge clk); rp_done = 1;
    #1 chk(!ren_ready, "R7 ready on done cycle", ren_ready, 0);
    @(posedge clk); #1 rp_done = 0;
    ren_op(10, 14, 13, r, p1, p2, pd);
    chk(r == 1, "R7 ready after done", r, 1);
    chk(p1 == 34, "R7 oldest-first replay", p1, 34);
    chk(p2 == 14, "R8 request ignored", p2, 14);
    chk(pd == 35, "R7 squashed reg returned", pd, 35);
    ren_op(9, 12, 0, r, p1, p2, pd);
    chk(p1 == 3 && p2 == 12, "R7 rebuilt entries", {p1, p2}, {6'd3, 6'd12});

    // R4: drain the pool
    bad = 0;
    for (int i = 0; i < 28; i++) begin
      ren_op(0, 0, 1, r, p1, p2, pd);
      if (!r || pd != 6'(36 + i)) bad++;
    end
    chk(bad == 0, "R3 drain order", bad, 0);
    @(negedge clk); ren_valid = 1; ren_dst = 1;
    #1 chk(!ren_ready, "R4 ready when empty", ren_ready, 0);
    @(posedge clk); #1 ren_valid = 0;
    ren_op(1, 0, 0, r, p1, p2, pd);
    chk(p1 == 63, "R4 stalled request no effect", p1, 63);
    retire(4, 36);
    ren_op(0, 0, 2, r, p1, p2, pd);
    chk(r && pd == 4, "R4/R5 ready after retire", pd, 4);

    finish_run();
  end
endmodule